// File: doc/BRIEF.md
# Packed Decimal Chain Arithmetic Unit

This block performs decimal arithmetic on an operand of packed binary-coded digits, two digits per byte by default. It can add a source operand to a destination operand, subtract the source from the destination, or negate the source (zero minus source). A carry-in flag (called X here) joins every operation, so a long decimal number can be handled one byte at a time. The least significant byte goes first and the most significant byte goes last, with X passing the decimal carry or borrow from one byte to the next.

A zero flag (Z) can only be cleared during a chain. After the last byte, Z therefore reports whether the whole number came out zero. A start pulse presets X to 0 and Z to 1 ahead of a new chain. One register stage holds the result byte and the flags. Each digit is corrected independently:
- after a binary add, a digit whose sum exceeds nine gains six;
- after a subtract, a digit that borrowed loses six.

Top module: `bcd_chain_unit`

## Requirements
- R1: With op code 0 (add), the result is (D + S + X) mod 10^DIGITS in packed decimal, where D is the destination, S the source and X the incoming extend flag. The carry is 1 exactly when D + S + X reaches 10^DIGITS.
- R2: With op code 1 (subtract), the result is D - S - X, with 10^DIGITS added if that is negative. The borrow is 1 exactly when D - S - X is negative.
- R3: With op code 2 (negate), the result is 0 - S - X in decimal, wrapped the same way as R2, and the destination input has no effect. The borrow is 1 exactly when S + X is nonzero.
- R4: The X and C outputs both equal the carry or borrow out of the most significant digit of the last operation.
- R5: Z becomes 0 when the result is nonzero. Otherwise Z keeps the value it had before the operation.
- R6: The N and V outputs are always 0.
- R7: Start without valid sets X=C=0 and Z=1 and leaves the result unchanged. Start together with valid runs that byte with incoming X=0 and Z=1.
- R8: Without start, each valid byte takes its incoming X and Z from the previous byte, so multi-byte numbers chain correctly.
- R9: A cycle without valid or start leaves result, X, C and Z unchanged, whatever the other inputs are.
- R10: After reset the outputs are result 0, X=C=0, Z=1 and out_valid 0.
- R11: Op code 3 behaves exactly as add.
- R12: out_valid is 1 exactly in the cycle after a cycle with valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Preset X=0, Z=1 for a new chain |
| valid_i | input | 1 | Process one byte this cycle |
| op_i | input | 2 | 0 add, 1 subtract, 2 negate, 3 add |
| src_i | input | 4*DIGITS | Source operand, packed decimal |
| dst_i | input | 4*DIGITS | Destination operand, packed decimal |
| result_o | output | 4*DIGITS | Registered result |
| x_o | output | 1 | Extend flag |
| c_o | output | 1 | Carry/borrow flag |
| z_o | output | 1 | Sticky zero flag |
| n_o | output | 1 | Negative flag, held 0 |
| v_o | output | 1 | Overflow flag, held 0 |
| out_valid_o | output | 1 | Result registered last cycle |

## Verification
Every result and flag is registered, so each is due on the first rising edge after the cycle in which valid or start was driven. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. The sweep runs every valid digit pair under each op and both extend values. Each tested byte is preceded by a priming byte that sets X, so each comparison looks at the output from exactly one preceding edge. Chain, hold and start checks follow the same rule of sampling one edge after their stimulus.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
   typedef enum logic [1:0] {
      BCD_ADD     = 2'd0,
      BCD_SUB     = 2'd1,
      BCD_NEG     = 2'd2,
      BCD_ADD_ALT = 2'd3
   } bcd_op_e;

   function automatic logic op_is_sub(input bcd_op_e op);
      return (op == BCD_SUB) || (op == BCD_NEG);
   endfunction

   function automatic logic op_zero_dst(input bcd_op_e op);
      return op == BCD_NEG;
   endfunction
endpackage

// File: rtl/bcd_digit_cell.sv
module bcd_digit_cell (
   input  logic       sub_i,
   input  logic [3:0] a_i,
   input  logic [3:0] b_i,
   input  logic       cin_i,
   output logic [3:0] d_o,
   output logic       cout_o
);
   logic [4:0] raw;

   always_comb begin
      if (sub_i) begin
         raw    = {1'b0, a_i} - {1'b0, b_i} - {4'b0, cin_i};
         cout_o = raw[4];
         d_o    = raw[4] ? (raw[3:0] - 4'd6) : raw[3:0];
      end else begin
         raw    = {1'b0, a_i} + {1'b0, b_i} + {4'b0, cin_i};
         cout_o = (raw > 5'd9);
         d_o    = cout_o ? (raw[3:0] + 4'd6) : raw[3:0];
      end
   end

   always_comb begin
      if (a_i <= 4'd9 && b_i <= 4'd9) begin
         // R1
         digit_range_chk: assert (d_o <= 4'd9);
      end
   end
endmodule

// File: rtl/bcd_byte_core.sv
module bcd_byte_core
   import bcd_pkg::*;
#(
   parameter int DIGITS = 2
) (
   input  bcd_op_e               op_i,
   input  logic [4*DIGITS-1:0]   src_i,
   input  logic [4*DIGITS-1:0]   dst_i,
   input  logic                  x_i,
   output logic [4*DIGITS-1:0]   res_o,
   output logic                  carry_o
);
   localparam int W = 4 * DIGITS;

   if (DIGITS < 1 || DIGITS > 8) begin : g_bad_digits
      $error("bcd_byte_core: DIGITS must be 1..8");
   end

   logic          sub;
   logic [W-1:0]  lhs;
   logic [DIGITS:0] chain;

   assign sub      = op_is_sub(op_i);
   assign lhs      = op_zero_dst(op_i) ? '0 : dst_i;
   assign chain[0] = x_i;

   for (genvar g = 0; g < DIGITS; g++) begin : g_digit
      bcd_digit_cell u_cell (
         .sub_i  (sub),
         .a_i    (lhs[4*g +: 4]),
         .b_i    (src_i[4*g +: 4]),
         .cin_i  (chain[g]),
         .d_o    (res_o[4*g +: 4]),
         .cout_o (chain[g+1])
      );
   end

   assign carry_o = chain[DIGITS];
endmodule

// File: rtl/bcd_flag_next.sv
module bcd_flag_next #(
   parameter int W = 8
) (
   input  logic [W-1:0] res_i,
   input  logic         carry_i,
   input  logic         z_i,
   output logic         x_o,
   output logic         z_o,
   output logic         n_o,
   output logic         v_o
);
   if (W < 4) begin : g_bad_width
      $error("bcd_flag_next: W must be at least 4");
   end

   assign x_o = carry_i;
   assign z_o = z_i & ~(|res_i);
   assign n_o = 1'b0;
   assign v_o = 1'b0;
endmodule

// File: rtl/bcd_chain_unit.sv
module bcd_chain_unit
   import bcd_pkg::*;
#(
   parameter int DIGITS = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                valid_i,
   input  logic [1:0]          op_i,
   input  logic [4*DIGITS-1:0] src_i,
   input  logic [4*DIGITS-1:0] dst_i,
   output logic [4*DIGITS-1:0] result_o,
   output logic                x_o,
   output logic                c_o,
   output logic                z_o,
   output logic                n_o,
   output logic                v_o,
   output logic                out_valid_o
);
   localparam int W = 4 * DIGITS;

   logic [W-1:0] res_q, core_res;
   logic         x_q, z_q, n_q, v_q, vld_q;
   logic         x_cur, z_cur, core_carry;
   logic         x_nx, z_nx, n_nx, v_nx;

   assign x_cur = start_i ? 1'b0 : x_q;
   assign z_cur = start_i ? 1'b1 : z_q;

   bcd_byte_core #(.DIGITS(DIGITS)) u_core (
      .op_i    (bcd_op_e'(op_i)),
      .src_i   (src_i),
      .dst_i   (dst_i),
      .x_i     (x_cur),
      .res_o   (core_res),
      .carry_o (core_carry)
   );

   bcd_flag_next #(.W(W)) u_flags (
      .res_i   (core_res),
      .carry_i (core_carry),
      .z_i     (z_cur),
      .x_o     (x_nx),
      .z_o     (z_nx),
      .n_o     (n_nx),
      .v_o     (v_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         x_q   <= 1'b0;
         z_q   <= 1'b1;
         n_q   <= 1'b0;
         v_q   <= 1'b0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= valid_i;
         if (valid_i) begin
            res_q <= core_res;
            x_q   <= x_nx;
            z_q   <= z_nx;
            n_q   <= n_nx;
            v_q   <= v_nx;
         end else if (start_i) begin
            x_q <= 1'b0;
            z_q <= 1'b1;
         end
      end
   end

   assign result_o    = res_q;
   assign x_o         = x_q;
   assign c_o         = x_q;
   assign z_o         = z_q;
   assign n_o         = n_q;
   assign v_o         = v_q;
   assign out_valid_o = vld_q;

   // R5
   z_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!z_q && !start_i) |=> !z_q);
   // R5
   z_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (core_res != '0)) |=> !z_q);
   // R12
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> out_valid_o);
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i && !start_i) |=> ($stable(res_q) && $stable(x_q) && $stable(z_q)));
   // R7
   start_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !valid_i) |=> (!x_q && z_q && $stable(res_q)));
   // R6
   nv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> (!n_o && !v_o));
endmodule

// File: tb/bcd_chain_unit_test.sv
module bcd_chain_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0, valid_i = 1'b0;
   logic [1:0] op_i = 2'd0;
   logic [7:0] src_i = 8'h00, dst_i = 8'h00;
   logic [7:0] result_o;
   logic       x_o, c_o, z_o, n_o, v_o, out_valid_o;

   int checks = 0, failures = 0;
   bit done = 0;

   bcd_chain_unit #(.DIGITS(2)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
      .op_i(op_i), .src_i(src_i), .dst_i(dst_i), .result_o(result_o),
      .x_o(x_o), .c_o(c_o), .z_o(z_o), .n_o(n_o), .v_o(v_o),
      .out_valid_o(out_valid_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] enc(input int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction

   function automatic int dec(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   // expected {result, x, c, z, n, v}
   function automatic logic [12:0] model(input logic [1:0] op, input int d,
                                         input int s, input int x, input bit zin);
      int t;
      bit cy;
      if (op == 2'd1)      t = d - s - x;
      else if (op == 2'd2) t = 0 - s - x;
      else                 t = d + s + x;
      if (op == 2'd1 || op == 2'd2) begin
         cy = (t < 0);
         if (cy) t = t + 100;
      end else begin
         cy = (t >= 100);
         if (cy) t = t - 100;
      end
      return {enc(t), cy, cy, zin && (t == 0), 1'b0, 1'b0};
   endfunction

   function automatic logic [12:0] outs();
      return {result_o, x_o, c_o, z_o, n_o, v_o};
   endfunction

   task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual res=%h x=%b c=%b z=%b n=%b v=%b expected res=%h x=%b c=%b z=%b n=%b v=%b",
                  req, act[12:5], act[4], act[3], act[2], act[1], act[0],
                  exp[12:5], exp[4], exp[3], exp[2], exp[1], exp[0]);
      end
   endtask

   task automatic check1(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic step(input logic st, input logic vl, input logic [1:0] op,
                       input logic [7:0] s, input logic [7:0] d);
      @(negedge clk);
      start_i = st; valid_i = vl; op_i = op; src_i = s; dst_i = d;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(3 * CLK_PERIOD);
      // R10 reset state
      check("R10", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
      check1("R10 out_valid", out_valid_o, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 R2 R4 R5 R6 exhaustive sweep of add and subtract
      for (int op = 0; op < 2; op++) begin
         for (int d = 0; d < 100; d++) begin
            for (int s = 0; s < 100; s++) begin
               for (int x = 0; x < 2; x++) begin
                  if (x == 1) step(1'b1, 1'b1, 2'd0, 8'h01, 8'h99);
                  else        step(1'b1, 1'b1, 2'd0, 8'h00, 8'h00);
                  step(1'b0, 1'b1, 2'(op), enc(s), enc(d));
                  check(op == 0 ? "R1 add" : "R2 sub", outs(),
                        model(2'(op), d, s, x, 1'b1));
               end
            end
         end
      end

      // R3 negate, destination driven with a non-zero pattern
      for (int s = 0; s < 100; s++) begin
         for (int x = 0; x < 2; x++) begin
            if (x == 1) step(1'b1, 1'b1, 2'd0, 8'h01, 8'h99);
            else        step(1'b1, 1'b1, 2'd0, 8'h00, 8'h00);
            step(1'b0, 1'b1, 2'd2, enc(s), 8'h57);
            check("R3 neg", outs(), model(2'd2, 0, s, x, 1'b1));
         end
      end

      // R11 op code 3 acts as add
      step(1'b1, 1'b1, 2'd3, 8'h67, 8'h45);
      check("R11", outs(), {8'h12, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
      step(1'b1, 1'b1, 2'd3, 8'h00, 8'h00);
      check("R11 zero", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

      // R5 sticky zero: nonzero byte then zero byte keeps Z low
      step(1'b1, 1'b1, 2'd0, 8'h00, 8'h01);
      check("R5 clear", outs(), {8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd0, 8'h00, 8'h00);
      check("R5 sticky", outs(), {8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});

      // R8 chain add 12345678 + 87654322 = 1_00000000
      step(1'b1, 1'b1, 2'd0, 8'h22, 8'h78);
      check("R8 add b0", outs(), {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd0, 8'h43, 8'h56);
      check("R8 add b1", outs(), {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd0, 8'h65, 8'h34);
      check("R8 add b2", outs(), {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd0, 8'h87, 8'h12);
      check("R8 add b3", outs(), {8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0});

      // R8 chain subtract 10000000 - 1 = 09999999
      step(1'b1, 1'b1, 2'd1, 8'h01, 8'h00);
      check("R8 sub b0", outs(), {8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd1, 8'h00, 8'h00);
      check("R8 sub b1", outs(), {8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd1, 8'h00, 8'h00);
      check("R8 sub b2", outs(), {8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd1, 8'h00, 8'h10);
      check("R8 sub b3", outs(), {8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
      check1("R12 valid high", out_valid_o, 1'b1);

      // R9 idle cycles with changing inputs hold all state
      step(1'b0, 1'b0, 2'd0, 8'h99, 8'h99);
      check("R9 idle1", outs(), {8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
      check1("R12 valid low", out_valid_o, 1'b0);
      step(1'b0, 1'b0, 2'd2, 8'h45, 8'h33);
      check("R9 idle2", outs(), {8'h09, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});

      // R7 start alone: leave X=1, Z=0 first, then preset
      step(1'b1, 1'b1, 2'd1, 8'h01, 8'h00);
      check("R7 setup", outs(), {8'h99, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
      step(1'b1, 1'b0, 2'd0, 8'h11, 8'h22);
      check("R7 start", outs(), {8'h99, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});
      step(1'b0, 1'b1, 2'd0, 8'h00, 8'h00);
      check("R7 after start", outs(), {8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0});

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule